// File: doc/BRIEF.md
# Indirect Table Access Engine

This block gives software indirect access to two internal configuration tables through a small register map. The first is a scheme table whose entries are each a run of 32-bit words. The second is a per-port partition table in which every port has two words. One word says which schemes are bound to the port. The other holds a classification-plan partition value.

Software uses a shared window of registers and a single action register. To write an entry, software fills the window and then writes a command to the action register. The command gives the direction, the target table, the entry index and, for port entries, which word to move. The GO bit (bit 31) of the action register reads back as 1 while the engine is busy. Software polls it until it clears and then reads the error bit. To read an entry, software issues a read command and, once GO has cleared, collects the data from the window.

The busy period has a fixed length. During that period, writes to the window and to the action register are ignored. A command that selects an index outside the table, or a table combination that does not exist, completes with the error bit set and changes nothing.

Top module: `kgx_indirect_engine`

## Requirements
- R1: After reset, the action register and every window word read as 0, and every table word holds 0.
- R2: An accepted action write sets GO (bit 31). GO reads as 1 for exactly BUSY_CYCLES clock cycles after the write edge and then reads as 0.
- R3: A write to the action register while GO is 1 is ignored. The pending command, its readback bits and the table and window contents are not affected by it.
- R4: A write to a window word while GO is 1 is ignored.
- R5: Window word i sits at byte offset 0x100+4*i, and the action register sits at 0x1FC. With bits 25 and 24 both 0, the command targets scheme entry bits 23:16. Bit 30 sets the direction. When bit 30 is 0, all window words are copied into the entry. When bit 30 is 1, all entry words are copied into the window.
- R6: On a scheme write, entry word CNT_WORD (default 16) is replaced only when bit 15 is 1. Otherwise it keeps its old value.
- R7: When bit 25 is 1 and bit 24 is 0, the command targets the port entry given by bits 7:0. Bit 15 moves window word 0 to or from the binding word. Bit 14 moves window word 1 to or from the plan word. Window words that are not selected are left unchanged.
- R8: The error bit is set, and no table or window word changes, in any of these cases: a scheme index of NUM_SCHEMES or more; a port index of NUM_PORTS or more; bits 25 and 24 both 1; bit 24 alone; a port command with neither bit 15 nor bit 14 set.
- R9: Action readback gives {GO, direction, error} in bits 31:29 and the accepted command's bits 28:0 below them. An accepted command clears the error bit. The error bit is valid once GO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |

## Verification
Most internal faults appear on the next action-register read or window read after a command completes. A wrong busy count moves the cycle in which GO falls. A wrong index or word-enable decode shows up later, when the entry is read back: the window holds a word from a different entry, or a word changed when it should not have. A lost error condition shows up as bit 29 reading 0 as soon as GO clears, and as altered contents on the following read of the entry that was hit.

// File: rtl/kgx_pkg.sv
// Package: shared command bit positions and decoded-operation type for the
// indirect table access engine. Assumes a 32-bit action word.
package kgx_pkg;
    localparam int CMD_GO_BIT   = 31;
    localparam int CMD_RD_BIT   = 30;
    localparam int CMD_ERR_BIT  = 29;
    localparam int CMD_PORT_BIT = 25;
    localparam int CMD_PLAN_BIT = 24;
    localparam int CMD_SIDX_LSB = 16;
    localparam int CMD_W15_BIT  = 15;
    localparam int CMD_W14_BIT  = 14;

    // Decoded view of one action command
    typedef struct packed {
        logic is_read;
        logic to_port;
        logic sel_sp;
        logic sel_cpp;
        logic upd_cnt;
        logic bad;
    } kg_op_t;
endpackage

// File: rtl/kgx_action_decode.sv
// Action decoder: turns the latched command word into a decoded operation,
// entry indices and a range/selection error flag. Purely combinational.
module kgx_action_decode
    import kgx_pkg::*;
#(
    parameter int NUM_SCHEMES = 32,
    parameter int NUM_PORTS   = 64,
    localparam int SIDX_W = $clog2(NUM_SCHEMES),
    localparam int PIDX_W = $clog2(NUM_PORTS)
) (
    input  logic [31:0]       cmd,
    output kg_op_t            op,
    output logic [SIDX_W-1:0] sidx,
    output logic [PIDX_W-1:0] pidx
);
    logic [31:0] sfield;
    logic [31:0] pfield;
    logic        unused_bits;

    assign sfield = {24'b0, cmd[CMD_SIDX_LSB +: 8]};
    assign pfield = {24'b0, cmd[7:0]};
    assign sidx   = cmd[CMD_SIDX_LSB +: SIDX_W];
    assign pidx   = cmd[0 +: PIDX_W];
    assign unused_bits = ^{cmd[31], cmd[29:26], cmd[13:8]};

    // Decode direction, target, word selects and legality
    always_comb begin
        op          = '0;
        op.is_read  = cmd[CMD_RD_BIT];
        op.to_port  = cmd[CMD_PORT_BIT];
        op.sel_sp   = cmd[CMD_PORT_BIT] & cmd[CMD_W15_BIT];
        op.sel_cpp  = cmd[CMD_PORT_BIT] & cmd[CMD_W14_BIT];
        op.upd_cnt  = ~cmd[CMD_PORT_BIT] & cmd[CMD_W15_BIT];
        if (cmd[CMD_PLAN_BIT]) begin
            op.bad = 1'b1;
        end else if (cmd[CMD_PORT_BIT]) begin
            op.bad = (pfield >= 32'(NUM_PORTS)) ||
                     !(cmd[CMD_W15_BIT] || cmd[CMD_W14_BIT]);
        end else begin
            op.bad = (sfield >= 32'(NUM_SCHEMES));
        end
    end
endmodule

// File: rtl/kgx_busy_seq.sv
// Busy sequencer: a fixed-length down-counter started by an accepted command.
// busy is high for BUSY_CYCLES cycles; done marks the last of them, the cycle
// whose closing edge performs the transfer. Assumes BUSY_CYCLES >= 1.
module kgx_busy_seq #(
    parameter int BUSY_CYCLES = 4,
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CNT_W-1:0] cnt;

    // Load on start, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(BUSY_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));
endmodule

// File: rtl/kgx_scheme_store.sv
// Scheme table: NUM entries of WORDS 32-bit words, written as a whole entry.
// The counter word is written only when upd_cnt is set. Read is combinational.
module kgx_scheme_store #(
    parameter int NUM      = 32,
    parameter int WORDS    = 24,
    parameter int CNT_WORD = 16,
    localparam int IDX_W = $clog2(NUM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             upd_cnt,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata [WORDS],
    output logic [31:0]      rdata [WORDS]
);
    for (genvar w = 0; w < WORDS; w++) begin : g_col
        logic [31:0] col [NUM];
        logic        wen;

        assign wen = we && ((w != CNT_WORD) || upd_cnt);

        // One storage column per word position
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int e = 0; e < NUM; e++) col[e] <= '0;
            end else if (wen) begin
                col[idx] <= wdata[w];
            end
        end

        assign rdata[w] = col[idx];
    end
endmodule

// File: rtl/kgx_port_store.sv
// Port partition table: per port a scheme-binding word and a plan word,
// each with its own write enable. Read is combinational.
module kgx_port_store #(
    parameter int NUM = 64,
    localparam int IDX_W = $clog2(NUM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_sp,
    input  logic             we_cpp,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wsp,
    input  logic [31:0]      wcpp,
    output logic [31:0]      rsp,
    output logic [31:0]      rcpp
);
    logic [31:0] sp_tab  [NUM];
    logic [31:0] cpp_tab [NUM];

    // Binding word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM; e++) sp_tab[e] <= '0;
        end else if (we_sp) begin
            sp_tab[idx] <= wsp;
        end
    end

    // Plan word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM; e++) cpp_tab[e] <= '0;
        end else if (we_cpp) begin
            cpp_tab[idx] <= wcpp;
        end
    end

    assign rsp  = sp_tab[idx];
    assign rcpp = cpp_tab[idx];
endmodule

// File: rtl/kgx_indirect_engine.sv
// Indirect table access engine top: register port, data window, action
// register, and the transfer between the window and the two tables.
// Assumes ADDR_W >= 9 (window at byte 0x100, action at byte 0x1FC) and
// WIN_WORDS >= 2 with WIN_WORDS <= 63.
module kgx_indirect_engine
    import kgx_pkg::*;
#(
    parameter int NUM_SCHEMES = 32,
    parameter int NUM_PORTS   = 64,
    parameter int WIN_WORDS   = 24,
    parameter int CNT_WORD    = 16,
    parameter int BUSY_CYCLES = 4,
    parameter int ADDR_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int SIDX_W   = $clog2(NUM_SCHEMES);
    localparam int PIDX_W   = $clog2(NUM_PORTS);
    localparam int WA_W     = ADDR_W - 2;
    localparam int WIDX_W   = $clog2(WIN_WORDS);
    localparam int WIN_BASE = 'h100 / 4;
    localparam int ACT_WORD = 'h1FC / 4;

    logic [WA_W-1:0]   wa;
    logic [WA_W-1:0]   win_off;
    logic              win_hit;
    logic              act_hit;
    logic              act_wr;
    logic              start;
    logic              busy;
    logic              done;
    logic              win_we;
    logic [31:0]       cmd_q;
    logic              err_q;
    kg_op_t            op;
    logic              op_bad;
    logic [SIDX_W-1:0] sidx;
    logic [PIDX_W-1:0] pidx;
    logic              sch_we;
    logic              port_we_sp;
    logic              port_we_cpp;
    logic              port_we;
    logic              xfer_rd;
    logic [31:0]       win    [WIN_WORDS];
    logic [31:0]       sch_rd [WIN_WORDS];
    logic [31:0]       port_rsp;
    logic [31:0]       port_rcpp;

    // Address decode of the register port
    assign wa      = bus_addr[ADDR_W-1:2];
    assign win_off = wa - WA_W'(WIN_BASE);
    assign win_hit = (32'(wa) >= WIN_BASE) && (32'(wa) < WIN_BASE + WIN_WORDS);
    assign act_hit = (32'(wa) == ACT_WORD);
    assign act_wr  = bus_wr && act_hit;
    assign start   = act_wr && !busy;
    assign win_we  = bus_wr && win_hit && !busy;

    kgx_busy_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .busy (busy),
        .done (done)
    );

    kgx_action_decode #(.NUM_SCHEMES(NUM_SCHEMES), .NUM_PORTS(NUM_PORTS)) u_dec (
        .cmd (cmd_q),
        .op  (op),
        .sidx(sidx),
        .pidx(pidx)
    );

    assign op_bad      = op.bad;
    assign xfer_rd     = done && !op.bad && op.is_read;
    assign sch_we      = done && !op.bad && !op.is_read && !op.to_port;
    assign port_we_sp  = done && !op.bad && !op.is_read && op.sel_sp;
    assign port_we_cpp = done && !op.bad && !op.is_read && op.sel_cpp;
    assign port_we     = port_we_sp || port_we_cpp;

    // Latch the accepted command; ignore action writes while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (start) begin
            cmd_q <= bus_wdata;
        end
    end

    // Error flag: cleared on acceptance, loaded at completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (start) begin
            err_q <= 1'b0;
        end else if (done) begin
            err_q <= op.bad;
        end
    end

    kgx_scheme_store #(.NUM(NUM_SCHEMES), .WORDS(WIN_WORDS), .CNT_WORD(CNT_WORD)) u_sch (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sch_we),
        .upd_cnt(op.upd_cnt),
        .idx    (sidx),
        .wdata  (win),
        .rdata  (sch_rd)
    );

    kgx_port_store #(.NUM(NUM_PORTS)) u_port (
        .clk   (clk),
        .rst_n (rst_n),
        .we_sp (port_we_sp),
        .we_cpp(port_we_cpp),
        .idx   (pidx),
        .wsp   (win[0]),
        .wcpp  (win[1]),
        .rsp   (port_rsp),
        .rcpp  (port_rcpp)
    );

    // Window words 2 and up: loaded by scheme reads or by software
    for (genvar w = 2; w < WIN_WORDS; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win[w] <= '0;
            end else if (xfer_rd && !op.to_port) begin
                win[w] <= sch_rd[w];
            end else if (win_we && (win_off[WIDX_W-1:0] == WIDX_W'(w))) begin
                win[w] <= bus_wdata;
            end
        end
    end

    // Window word 0: scheme reads, binding-word reads or software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win[0] <= '0;
        end else if (xfer_rd && !op.to_port) begin
            win[0] <= sch_rd[0];
        end else if (xfer_rd && op.sel_sp) begin
            win[0] <= port_rsp;
        end else if (win_we && (win_off[WIDX_W-1:0] == '0)) begin
            win[0] <= bus_wdata;
        end
    end

    // Window word 1: scheme reads, plan-word reads or software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win[1] <= '0;
        end else if (xfer_rd && !op.to_port) begin
            win[1] <= sch_rd[1];
        end else if (xfer_rd && op.sel_cpp) begin
            win[1] <= port_rcpp;
        end else if (win_we && (win_off[WIDX_W-1:0] == WIDX_W'(1))) begin
            win[1] <= bus_wdata;
        end
    end

    // Read-back multiplexer
    always_comb begin
        bus_rdata = '0;
        if (act_hit) begin
            bus_rdata = {busy, cmd_q[CMD_RD_BIT], err_q, cmd_q[28:0]};
        end else if (win_hit) begin
            bus_rdata = win[win_off[WIDX_W-1:0]];
        end
    end
endmodule

// File: rtl/kgx_indirect_engine_chk.sv
// Checker: temporal properties of the engine's handshake, locking and
// write-enable behaviour. Bound to the top module below.
module kgx_indirect_engine_chk #(
    parameter int BUSY_CYCLES = 4,
    localparam int CW = $clog2(BUSY_CYCLES + 2)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        start,
    input logic        act_wr,
    input logic [31:0] cmd_q,
    input logic        err_q,
    input logic        bad,
    input logic        sch_we,
    input logic        port_we,
    input logic        win_we
);
    logic [CW-1:0] elapsed;

    // Independent count of cycles since the accepted command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (start) begin
            elapsed <= CW'(1);
        end else if (done) begin
            elapsed <= '0;
        end else if (busy) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    assert_go_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (elapsed == CW'(BUSY_CYCLES)));

    assert_go_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_busy_cmd_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && act_wr) |=> (cmd_q == $past(cmd_q)));

    assert_window_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !win_we);

    assert_single_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sch_we, port_we}));

    assert_error_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bad) |-> !(sch_we || port_we));

    assert_error_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !err_q));
endmodule

bind kgx_indirect_engine kgx_indirect_engine_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .start  (start),
    .act_wr (act_wr),
    .cmd_q  (cmd_q),
    .err_q  (err_q),
    .bad    (op_bad),
    .sch_we (sch_we),
    .port_we(port_we),
    .win_we (win_we)
);

// File: tb/kgx_indirect_engine_test.sv
// Bench: vector table of commands with expected status and window word,
// then directed tests for reset, GO timing and busy-time write locking.
module kgx_indirect_engine_test;
    localparam int WIN   = 24;
    localparam int BUSY  = 4;
    localparam logic [8:0] ACT = 9'h1FC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int          checks = 0;
    int          failures = 0;

    always #5 clk = ~clk;

    kgx_indirect_engine uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    typedef struct packed {
        logic [31:0] act;
        logic [31:0] seed;   // 0: leave window as is
        logic        err;
        logic [7:0]  word;   // 8'hFF: no window check
        logic [31:0] val;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{32'h8003_8000, 32'h1000_0000, 1'b0, 8'hFF, 32'h0},          // R5 write s3, R6 counter
        '{32'hC003_0000, 32'hAAAA_0000, 1'b0, 8'd5,  32'h1000_0005},  // R5
        '{32'hC003_0000, 32'hAAAA_0000, 1'b0, 8'd16, 32'h1000_0010},  // R6 counter taken
        '{32'h8003_0000, 32'h2000_0000, 1'b0, 8'hFF, 32'h0},          // R6 no update
        '{32'hC003_0000, 32'hAAAA_0000, 1'b0, 8'd16, 32'h1000_0010},  // R6 counter kept
        '{32'hC003_0000, 32'hAAAA_0000, 1'b0, 8'd2,  32'h2000_0002},  // R5
        '{32'h801F_8000, 32'h3100_0000, 1'b0, 8'hFF, 32'h0},          // R5 last scheme
        '{32'hC01F_0000, 32'hAAAA_0000, 1'b0, 8'd23, 32'h3100_0017},  // R5 last word
        '{32'h8020_8000, 32'h5500_0000, 1'b1, 8'hFF, 32'h0},          // R8 scheme 32
        '{32'h8303_8000, 32'h7700_0000, 1'b1, 8'hFF, 32'h0},          // R8 both tables
        '{32'hC003_0000, 32'hAAAA_0000, 1'b0, 8'd2,  32'h2000_0002},  // R8 untouched, R9 clear
        '{32'h8200_8005, 32'h4000_0000, 1'b0, 8'hFF, 32'h0},          // R7 binding write
        '{32'h8200_4005, 32'h5000_0000, 1'b0, 8'hFF, 32'h0},          // R7 plan write
        '{32'hC200_C005, 32'h0F00_0000, 1'b0, 8'd0,  32'h4000_0000},  // R7
        '{32'hC200_C005, 32'h0F00_0000, 1'b0, 8'd1,  32'h5000_0001},  // R7
        '{32'hC200_8005, 32'h0F00_0000, 1'b0, 8'd1,  32'h0F00_0001},  // R7 word1 untouched
        '{32'h8200_803F, 32'h6300_0000, 1'b0, 8'hFF, 32'h0},          // R7 last port
        '{32'hC200_803F, 32'h0F00_0000, 1'b0, 8'd0,  32'h6300_0000},  // R7
        '{32'h8200_8040, 32'h6400_0000, 1'b1, 8'hFF, 32'h0},          // R8 port 64
        '{32'h8200_0005, 32'h6500_0000, 1'b1, 8'hFF, 32'h0},          // R8 no word
        '{32'h8100_0000, 32'h6600_0000, 1'b1, 8'hFF, 32'h0},          // R8 plan table
        '{32'h8300_8005, 32'h9900_0000, 1'b1, 8'hFF, 32'h0},          // R8 both tables
        '{32'hC200_8005, 32'h0F00_0000, 1'b0, 8'd0,  32'h4000_0000},  // R8 port untouched
        '{32'hC020_0000, 32'h0F00_0000, 1'b1, 8'd3,  32'h0F00_0003}   // R8 read keeps window
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic fill(input logic [31:0] seed);
        for (int i = 0; i < WIN; i++) wr(9'h100 + 9'(4 * i), seed ^ 32'(i));
    endtask

    task automatic wait_idle(output logic [31:0] st);
        rd(ACT, st);
        for (int n = 0; n < 100 && st[31]; n++) begin
            @(negedge clk);
            rd(ACT, st);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        int          n;
        string       tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(ACT, r);       check("R1 action", r, 32'h0);
        rd(9'h100, r);    check("R1 window0", r, 32'h0);
        rd(9'h15C, r);    check("R1 window23", r, 32'h0);
        fill(32'h1234_0000);
        wr(ACT, 32'hC000_0000);
        wait_idle(r);
        rd(9'h10C, r);    check("R1 scheme0 empty", r, 32'h0);

        // R2: GO length
        wr(ACT, 32'hC001_0000);
        rd(ACT, r);       check("R2 GO set", {31'b0, r[31]}, 32'h1);
        n = 0;
        while (r[31] && n < 50) begin
            @(negedge clk);
            n++;
            rd(ACT, r);
        end
        check("R2 GO cycles", 32'(n), 32'(BUSY));

        // Vector table
        for (int v = 0; v < NV; v++) begin
            tag = VEC[v].err ? "R8" : (VEC[v].act[25] ? "R7" : "R5");
            if (VEC[v].seed != 0) fill(VEC[v].seed);
            wr(ACT, VEC[v].act);
            wait_idle(r);
            check("R9 status", r, {1'b0, VEC[v].act[30], VEC[v].err, VEC[v].act[28:0]});
            if (VEC[v].word != 8'hFF) begin
                rd(9'h100 + 9'(4 * VEC[v].word), r);
                check(tag, r, VEC[v].val);
            end
        end

        // R3 and R4: writes while busy are ignored
        fill(32'h7700_0000);
        wr(ACT, 32'h8007_8000);
        wr(ACT, 32'hC003_0000);
        wr(9'h110, 32'hDEAD_BEEF);
        wait_idle(r);
        check("R3 command kept", r, 32'h0007_8000);
        rd(9'h108, r);    check("R3 window not reloaded", r, 32'h7700_0002);
        rd(9'h110, r);    check("R4 window word4", r, 32'h7700_0004);
        fill(32'h0F00_0000);
        wr(ACT, 32'hC007_0000);
        wait_idle(r);
        rd(9'h110, r);    check("R4 table word4", r, 32'h7700_0004);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule